// File: doc/BRIEF.md
# Trigger Countdown and Output Controller

This block takes an asynchronous trigger pin, resynchronises it to the sampling clock and detects edges of a selectable direction. It counts those events down to a final trigger. On the final trigger it sets a sticky status flag, can raise a debug interrupt request, and drives a trigger output pin in one of three modes: a one-clock low pulse, a one-clock high pulse, or a level toggle. With automatic rearm enabled, the countdown restarts from a separate reload value after each final trigger. Without rearm, the block halts until software writes a fresh count.

Software configures the block through a synchronous select/write port. Four select codes address four words: control, current count, reload count and status. The read data is a combinational view of the selected word.

The counter is a two-state machine. `CS_ARMED` counts events. The transition *final-with-rearm* reloads the count and stays in `CS_ARMED`. The transition *final-no-rearm* goes to `CS_HALTED`. In `CS_HALTED`, events are dropped. The transition *count-write* returns the machine from any state to `CS_ARMED`.

Top module: `tcu_top`

## Requirements
- R1: After reset the following all read zero: control, count, reload and status. `final_flag` and `dbg_irq` are 0 and `trig_out` is 1. The synchronizer flops reset high.
- R2: The control word (select 0) has these fields: bit 0 is polarity, bits 2:1 are output mode, bit 3 is rearm enable, bit 4 is interrupt enable. With polarity 0 an event is a 1-to-0 transition of the synchronised input; with polarity 1 it is a 0-to-1 transition. The opposite transition is not an event. A `trig_in` change sampled at one clock edge takes effect at the third clock edge from that one.
- R3: In `CS_ARMED`, each event with a nonzero count decrements the count (select 1) by one.
- R4: An event in `CS_ARMED` with count zero is the final trigger. Without rearm the count stays zero, with no wrap, and the machine enters `CS_HALTED`. There, events change neither the count, the flag nor the output until the count is written.
- R5: When a final trigger occurs with rearm enabled, the count is loaded from the reload word (select 2) and the machine stays in `CS_ARMED`.
- R6: Output mode 0 and mode 3 idle high and drive low for exactly one clock on a final trigger. Mode 1 idles low and drives high for exactly one clock. The pulse starts on the same edge that sets the flag.
- R7: Output mode 2 inverts the output level on each final trigger and holds it between final triggers. The toggle level resets to 0.
- R8: `final_flag` (status bit 0) is sticky. Writing select 3 with bit 0 = 1 clears it, and bit 0 = 0 has no effect. When a final trigger and a clear land in the same cycle, the flag stays set.
- R9: `dbg_irq` is high exactly when `final_flag` is set and interrupt enable is 1.
- R10: Reading control and reload returns the last value written.
- R11: When a count write and an event land in the same cycle, the written value wins and the event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_sel | input | 2 | Word select: 0 control, 1 count, 2 reload, 3 status |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected word |
| trig_in | input | 1 | Raw asynchronous trigger pin |
| trig_out | output | 1 | Trigger output pin |
| final_flag | output | 1 | Sticky final-trigger flag |
| dbg_irq | output | 1 | Debug interrupt request |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a final trigger and a software flag-clear. The bench times a status write so that its clock edge is exactly the third edge after the input change, the edge on which the final trigger registers. It then judges that the flag reads set afterwards.

The second pair is a count write and a non-final event. It is provoked with the same timing, and the count must read back the written value rather than that value minus one.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef enum logic {
        CS_ARMED  = 1'b0,
        CS_HALTED = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        OM_PULSE_LO = 2'd0,
        OM_PULSE_HI = 2'd1,
        OM_TOGGLE   = 2'd2,
        OM_RESERVED = 2'd3
    } out_mode_e;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_RELOAD = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    localparam int CB_POL    = 0;
    localparam int CB_MODE   = 1;
    localparam int CB_REARM  = 3;
    localparam int CB_IRQEN  = 4;
    localparam int CTRL_W    = 5;

endpackage

// File: rtl/tcu_sync_edge.sv
module tcu_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pol_rise,
    output logic evt
);
    logic stage_q [STAGES];
    logic prev_q;
    logic synced;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= 1'b1;
                else        stage_q[g] <= raw_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= 1'b1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign synced = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= synced;
    end

    always_comb begin
        if (pol_rise) evt = synced & ~prev_q;
        else          evt = ~synced & prev_q;
    end

    // R2
    evt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

endmodule

// File: rtl/tcu_cfg_regs.sv
module tcu_cfg_regs
    import tcu_pkg::*;
#(
    parameter int WD_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [WD_W-1:0]   wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              pol_rise,
    output out_mode_e         mode,
    output logic              rearm_en,
    output logic              irq_en,
    output logic              cnt_wr,
    output logic              clr_wr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else if (wr) begin
            if (sel == SEL_CTRL)   ctrl_q   <= wdata[CTRL_W-1:0];
            if (sel == SEL_RELOAD) reload_q <= wdata[CNT_W-1:0];
        end
    end

    assign pol_rise = ctrl_q[CB_POL];
    assign mode     = out_mode_e'(ctrl_q[CB_MODE +: 2]);
    assign rearm_en = ctrl_q[CB_REARM];
    assign irq_en   = ctrl_q[CB_IRQEN];
    assign cnt_wr   = wr && (sel == SEL_COUNT);
    assign clr_wr   = wr && (sel == SEL_STATUS) && wdata[0];

    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/tcu_count_fsm.sv
module tcu_count_fsm
    import tcu_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             clr_wr,
    input  logic             rearm_en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             final_flag,
    output logic             final_hit
);
    cnt_state_e       state_q, state_n;
    logic [CNT_W-1:0] count_n;
    logic             flag_q, flag_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_ARMED;
            count_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
            flag_q  <= flag_n;
        end
    end

    always_comb begin
        state_n   = state_q;
        count_n   = count_q;
        final_hit = 1'b0;
        if (cnt_wr) begin
            count_n = cnt_wdata;
            state_n = CS_ARMED;
        end else begin
            unique case (state_q)
                CS_ARMED: begin
                    if (evt) begin
                        if (count_q != '0) begin
                            count_n = count_q - 1'b1;
                        end else begin
                            final_hit = 1'b1;
                            if (rearm_en) count_n = reload;
                            else          state_n = CS_HALTED;
                        end
                    end
                end
                CS_HALTED: begin
                    state_n = CS_HALTED;
                end
                default: state_n = CS_ARMED;
            endcase
        end
        if (final_hit)   flag_n = 1'b1;
        else if (clr_wr) flag_n = 1'b0;
        else             flag_n = flag_q;
    end

    assign final_flag = flag_q;

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_ARMED && evt && !cnt_wr && count_q != '0)
        |=> count_q == $past(count_q) - 1'b1);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_ARMED && evt && !cnt_wr && count_q == '0 && !rearm_en)
        |=> (count_q == '0 && state_q == CS_HALTED));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HALTED && !cnt_wr) |=> ($stable(count_q) && $stable(state_q)));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (final_hit && rearm_en) |=> (count_q == $past(reload) && state_q == CS_ARMED));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        final_hit |=> final_flag);

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count_q == $past(cnt_wdata));

endmodule

// File: rtl/tcu_out_drv.sv
module tcu_out_drv
    import tcu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  logic      final_hit,
    output logic      trig_out
);
    logic pulse_q;
    logic tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            pulse_q <= final_hit && (mode != OM_TOGGLE);
            if (final_hit && mode == OM_TOGGLE) tog_q <= ~tog_q;
        end
    end

    always_comb begin
        unique case (mode)
            OM_PULSE_LO: trig_out = ~pulse_q;
            OM_PULSE_HI: trig_out = pulse_q;
            OM_TOGGLE:   trig_out = tog_q;
            OM_RESERVED: trig_out = ~pulse_q;
            default:     trig_out = ~pulse_q;
        endcase
    end

    // R6
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_PULSE_HI && trig_out) |=> (!trig_out || mode != OM_PULSE_HI));

    // R7
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_TOGGLE && !final_hit) |=> ($stable(trig_out) || mode != OM_TOGGLE));

endmodule

// File: rtl/tcu_top.sv
module tcu_top
    import tcu_pkg::*;
#(
    parameter int WD_W        = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_sel,
    input  logic [WD_W-1:0] cfg_wdata,
    output logic [WD_W-1:0] cfg_rdata,
    input  logic            trig_in,
    output logic            trig_out,
    output logic            final_flag,
    output logic            dbg_irq
);
    localparam int CTRL_PAD = WD_W - CTRL_W;
    localparam int CNT_PAD  = WD_W - CNT_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count_q;
    logic              pol_rise, rearm_en, irq_en, cnt_wr, clr_wr;
    logic              evt, final_hit;
    out_mode_e         mode;

    tcu_cfg_regs #(.WD_W(WD_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .pol_rise(pol_rise), .mode(mode),
        .rearm_en(rearm_en), .irq_en(irq_en), .cnt_wr(cnt_wr), .clr_wr(clr_wr)
    );

    tcu_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_in(trig_in), .pol_rise(pol_rise), .evt(evt)
    );

    tcu_count_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .cnt_wr(cnt_wr),
        .cnt_wdata(cfg_wdata[CNT_W-1:0]), .clr_wr(clr_wr), .rearm_en(rearm_en),
        .reload(reload_q), .count_q(count_q), .final_flag(final_flag),
        .final_hit(final_hit)
    );

    tcu_out_drv drv_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .final_hit(final_hit),
        .trig_out(trig_out)
    );

    assign dbg_irq = final_flag & irq_en;

    always_comb begin
        unique case (cfg_sel)
            SEL_CTRL:   cfg_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
            SEL_COUNT:  cfg_rdata = {{CNT_PAD{1'b0}}, count_q};
            SEL_RELOAD: cfg_rdata = {{CNT_PAD{1'b0}}, reload_q};
            SEL_STATUS: cfg_rdata = {{(WD_W-1){1'b0}}, final_flag};
            default:    cfg_rdata = '0;
        endcase
    end

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> (final_flag && ctrl_q[CB_IRQEN]));

endmodule

// File: tb/tcu_top_tb_top.sv
`timescale 1ns/1ps
module tcu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        trig_in;
    logic        trig_out;
    logic        final_flag;
    logic        dbg_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tcu_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_in(trig_in),
        .trig_out(trig_out), .final_flag(final_flag), .dbg_irq(dbg_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [15:0] exp);
        cfg_sel = sel;
        #1;
        chk(req, "readback", cfg_rdata, exp);
    endtask

    task automatic set_in(input logic v);
        @(negedge clk);
        trig_in = v;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic to_final_cycle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1", 2'd0, 16'h0);
        rd_chk("R1", 2'd1, 16'h0);
        rd_chk("R1", 2'd2, 16'h0);
        rd_chk("R1", 2'd3, 16'h0);
        chk("R1", "trig_out", {15'b0, trig_out}, 16'h1);
        chk("R1", "final_flag", {15'b0, final_flag}, 16'h0);
        chk("R1", "dbg_irq", {15'b0, dbg_irq}, 16'h0);
    endtask

    task automatic t_default_final();
        logic seen_low;
        set_in(1'b0);
        to_final_cycle();
        chk("R6", "mode0 pulse low", {15'b0, trig_out}, 16'h0);
        chk("R4", "flag on final", {15'b0, final_flag}, 16'h1);
        @(negedge clk);
        chk("R6", "mode0 back high", {15'b0, trig_out}, 16'h1);
        rd_chk("R4", 2'd1, 16'h0);
        set_in(1'b1);
        settle();
        seen_low = 1'b0;
        set_in(1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!trig_out) seen_low = 1'b1;
        end
        chk("R4", "halted output quiet", {15'b0, seen_low}, 16'h0);
        rd_chk("R4", 2'd1, 16'h0);
        set_in(1'b1);
        settle();
    endtask

    task automatic t_clear();
        cfg_write(2'd3, 16'h0);
        rd_chk("R8", 2'd3, 16'h1);
        cfg_write(2'd3, 16'h1);
        chk("R8", "flag cleared", {15'b0, final_flag}, 16'h0);
    endtask

    task automatic t_pol_count();
        cfg_write(2'd0, 16'h0003);
        rd_chk("R10", 2'd0, 16'h0003);
        chk("R6", "mode1 idle low", {15'b0, trig_out}, 16'h0);
        cfg_write(2'd1, 16'h0002);
        rd_chk("R3", 2'd1, 16'h2);
        set_in(1'b0);
        settle();
        rd_chk("R2", 2'd1, 16'h2);
        set_in(1'b1);
        settle();
        rd_chk("R3", 2'd1, 16'h1);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        settle();
        rd_chk("R3", 2'd1, 16'h0);
        chk("R3", "no early final", {15'b0, final_flag}, 16'h0);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        to_final_cycle();
        chk("R6", "mode1 pulse high", {15'b0, trig_out}, 16'h1);
        chk("R2", "rising final flag", {15'b0, final_flag}, 16'h1);
        @(negedge clk);
        chk("R6", "mode1 back low", {15'b0, trig_out}, 16'h0);
    endtask

    task automatic t_mode3();
        cfg_write(2'd3, 16'h1);
        cfg_write(2'd0, 16'h000F);
        cfg_write(2'd1, 16'h0000);
        chk("R6", "mode3 idle high", {15'b0, trig_out}, 16'h1);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        to_final_cycle();
        chk("R6", "mode3 pulse low", {15'b0, trig_out}, 16'h0);
        @(negedge clk);
        chk("R6", "mode3 back high", {15'b0, trig_out}, 16'h1);
    endtask

    task automatic t_rearm_toggle();
        cfg_write(2'd3, 16'h1);
        cfg_write(2'd2, 16'h0001);
        rd_chk("R10", 2'd2, 16'h1);
        cfg_write(2'd0, 16'd29);
        cfg_write(2'd1, 16'h0000);
        chk("R7", "toggle reset level", {15'b0, trig_out}, 16'h0);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        to_final_cycle();
        chk("R7", "toggle to 1", {15'b0, trig_out}, 16'h1);
        rd_chk("R5", 2'd1, 16'h1);
        chk("R9", "irq raised", {15'b0, dbg_irq}, 16'h1);
        @(negedge clk);
        chk("R7", "toggle holds", {15'b0, trig_out}, 16'h1);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        settle();
        rd_chk("R5", 2'd1, 16'h0);
        chk("R7", "hold on non-final", {15'b0, trig_out}, 16'h1);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        settle();
        chk("R7", "toggle to 0", {15'b0, trig_out}, 16'h0);
        rd_chk("R5", 2'd1, 16'h1);
        cfg_write(2'd0, 16'd13);
        chk("R9", "irq gated off", {15'b0, dbg_irq}, 16'h0);
        chk("R9", "flag still set", {15'b0, final_flag}, 16'h1);
    endtask

    task automatic t_same_cycle();
        cfg_write(2'd2, 16'h0000);
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd3, 16'h1);
        chk("R8", "flag clear before race", {15'b0, final_flag}, 16'h0);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        @(negedge clk);
        cfg_write(2'd3, 16'h1);
        chk("R8", "set wins over clear", {15'b0, final_flag}, 16'h1);
        cfg_write(2'd1, 16'h0003);
        set_in(1'b0);
        settle();
        set_in(1'b1);
        @(negedge clk);
        cfg_write(2'd1, 16'h0005);
        settle();
        rd_chk("R11", 2'd1, 16'h5);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = 16'h0; trig_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_final();
        t_clear();
        t_pol_count();
        t_mode3();
        t_rearm_toggle();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule